// File: doc/BRIEF.md
# Three-Wire Serial Word Store (64 x 16)

This block is a synthesizable slave that behaves like a small three-wire serial EEPROM holding 64 words of 16 bits. An external master drives a chip select, a serial clock and a data line. The block drives one data output and an enable for that output. All three inputs are sampled by a faster system clock through synchronisers, and the block acts on serial-clock rising edges that it detects internally. The stored words are kept in an internal register array, which is cleared to zero at reset.

A command is a start bit, a two-bit opcode and a six-bit address, all sent most significant bit first. Leading zeros before the start bit are skipped. A read command returns a dummy zero and then the addressed word. If the serial clock keeps running and chip select stays high, the block goes on to return the words at the following addresses. A write command carries 16 data bits. The word is stored when chip select falls. While chip select is high again, the data output then shows whether the internal write time is still running. Any fall of chip select returns the command decoder to its waiting state.

Top module: `tw_eeprom_slave`

## Requirements
- R1: `do_oe_o` is low after reset and whenever chip select has been low for at least three system clocks.
- R2: With chip select high, zeros on the data input before the first 1 are ignored. The first sampled 1 is the start bit.
- R3: Opcode `10` after the start bit, followed by address bits A5 to A0, selects a read. On the serial-clock rise that samples A0, `do_o` is driven to 0 with `do_oe_o` high.
- R4: After the dummy zero, each following serial-clock rise puts one data bit on `do_o`, from bit 15 down to bit 0 of the addressed word.
- R5: While chip select stays high, the rise after bit 0 starts bit 15 of the word at the next address. The address wraps from 63 to 0.
- R6: Opcode `01`, then six address bits, then 16 data bits (MSB first), stores the word at that address when chip select next falls.
- R7: After a stored write, `do_oe_o` is high whenever chip select is high. `do_o` is 0 for `WRITE_CYCLES` system clocks from the store, and 1 after that time.
- R8: The status output stops (`do_oe_o` low) once the next start bit is received.
- R9: If chip select falls before a command is complete, nothing is stored, no status is shown, and the next command decodes normally.
- R10: Opcodes `00` and `11` never enable `do_o` and never change the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the master |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read data, or status (0 busy, 1 ready) |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
Random reads and writes use random addresses and data, a random number of leading zeros, and a random number of consecutive words per read. Comparing every word against a bench model separates addressing faults from bit-order faults. Directed reads starting at address 63 expose a wrong wrap or a missing increment. A write whose status is sampled both early and late in the window distinguishes a timer that never starts from one that never ends. Commands cut short by chip select, and commands with the two unused opcodes, each followed by a read-back of the target word, show that the decoder restarts cleanly and that the stored words stay untouched.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_WDONE,
    ST_HOLD
  } fsm_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/tw_in_sync.sv
module tw_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_word_mem.sv
module tw_word_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
  parameter int WRITE_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic start_i,
  output logic busy_o,
  output logic status_vld_o
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             status_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      status_vld_q <= 1'b0;
    end else begin
      if (commit_i) cnt_q <= CNT_W'(WRITE_CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;

      if (commit_i) status_vld_q <= 1'b1;
      else if (start_i) status_vld_q <= 1'b0;
    end
  end

  assign busy_o       = (cnt_q != '0);
  assign status_vld_o = status_vld_q;

  a_r7_busy_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i));

  a_r7_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !commit_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !commit_i) |=> !status_vld_q);
endmodule

// File: rtl/tw_cmd_fsm.sv
module tw_cmd_fsm
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              start_o,
  output logic              rd_active_o,
  output logic              dout_o
);
  localparam int MAX_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAX_W);

  fsm_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        op_q;
  logic [ADDR_W-2:0] addr_sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] wdat_q;
  logic              sk_d_q, rd_active_q, dout_q, start_q, commit_q;
  logic              sk_rise;
  logic [ADDR_W-1:0] addr_full;

  assign sk_rise   = sk_i & ~sk_d_q;
  assign addr_full = {addr_sh_q, di_i};

  // next word is fetched one address ahead while streaming
  assign mem_raddr_o = (state_q == ST_ADDR) ? addr_full : addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      op_q        <= '0;
      addr_sh_q   <= '0;
      addr_q      <= '0;
      shreg_q     <= '0;
      wdat_q      <= '0;
      sk_d_q      <= 1'b0;
      rd_active_q <= 1'b0;
      dout_q      <= 1'b0;
      start_q     <= 1'b0;
      commit_q    <= 1'b0;
    end else begin
      sk_d_q   <= sk_i;
      start_q  <= 1'b0;
      commit_q <= 1'b0;
      if (!cs_i) begin
        commit_q    <= (state_q == ST_WDONE) && !busy_i;
        state_q     <= ST_IDLE;
        rd_active_q <= 1'b0;
      end else if (sk_rise) begin
        unique case (state_q)
          ST_IDLE: begin
            if (di_i) begin
              start_q <= 1'b1;
              cnt_q   <= CNT_W'(1);
              state_q <= ST_OPC;
            end
          end
          ST_OPC: begin
            op_q <= {op_q[0], di_i};
            if (cnt_q == '0) begin
              cnt_q   <= CNT_W'(ADDR_W - 1);
              state_q <= ST_ADDR;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_ADDR: begin
            addr_sh_q <= addr_full[ADDR_W-2:0];
            if (cnt_q == '0) begin
              addr_q <= addr_full;
              cnt_q  <= CNT_W'(DATA_W - 1);
              if (op_q == OP_READ) begin
                rd_active_q <= 1'b1;
                dout_q      <= 1'b0;
                shreg_q     <= mem_rdata_i;
                state_q     <= ST_RDATA;
              end else if (op_q == OP_WRITE) begin
                state_q <= ST_WDATA;
              end else begin
                state_q <= ST_HOLD;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_RDATA: begin
            dout_q <= shreg_q[DATA_W-1];
            if (cnt_q == '0) begin
              addr_q  <= addr_q + 1'b1;
              shreg_q <= mem_rdata_i;
              cnt_q   <= CNT_W'(DATA_W - 1);
            end else begin
              shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
              cnt_q   <= cnt_q - 1'b1;
            end
          end
          ST_WDATA: begin
            wdat_q <= {wdat_q[DATA_W-2:0], di_i};
            if (cnt_q == '0) state_q <= ST_WDONE;
            else cnt_q <= cnt_q - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o     = commit_q;
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = wdat_q;
  assign start_o     = start_q;
  assign rd_active_o = rd_active_q;
  assign dout_o      = dout_q;

  a_r9_cs_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (state_q == ST_IDLE && !rd_active_q));

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && sk_rise && state_q == ST_RDATA && cnt_q == '0)
      |=> (addr_q == $past(addr_q) + 1'b1));

  a_r3_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active_q) |-> !dout_q);

  a_r10_no_commit_bad_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> (op_q == OP_WRITE));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_s, sk_s, di_s;
  logic [DATA_W-1:0] mem_rdata;
  logic [ADDR_W-1:0] mem_raddr, wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en, start, rd_active, dout, busy, status_vld;

  tw_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sk_i, di_i}),
    .q_o    ({cs_s, sk_s, di_s})
  );

  tw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_s),
    .sk_i        (sk_s),
    .di_i        (di_s),
    .busy_i      (busy),
    .mem_rdata_i (mem_rdata),
    .mem_raddr_o (mem_raddr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .start_o     (start),
    .rd_active_o (rd_active),
    .dout_o      (dout)
  );

  tw_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (mem_raddr),
    .rd_data_o (mem_rdata)
  );

  tw_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (wr_en),
    .start_i      (start),
    .busy_o       (busy),
    .status_vld_o (status_vld)
  );

  assign do_oe_o = cs_s & (rd_active | status_vld);
  assign do_o    = rd_active ? dout : ~busy;

  a_r1_stop_drive_after_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !$past(cs_s)) |-> !do_oe_o);
endmodule

// File: tb/tw_eeprom_slave_test.sv
module tw_eeprom_slave_test;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int WC   = 200;
  localparam int HALF = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0;
  logic sk_i = 1'b0;
  logic di_i = 1'b0;
  logic do_o, do_oe_o;

  logic [DW-1:0] ref_mem [64];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tw_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC)) uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_i),
    .sk_i    (sk_i),
    .di_i    (di_i),
    .do_o    (do_o),
    .do_oe_o (do_oe_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic d, output logic oe);
    di_i = b;
    tick(HALF);
    sk_i = 1'b1;
    tick(HALF);
    d  = do_o;
    oe = do_oe_o;
    sk_i = 1'b0;
  endtask

  task automatic cs_cycle();
    cs_i = 1'b0;
    tick(4);
    chk("R1 cs low", 32'(do_oe_o), 32'd0);
    cs_i = 1'b1;
    tick(4);
  endtask

  // leading zeros (R2), start, opcode, address MSB first; returns A0 sample
  task automatic send_hdr(input int nz, input logic [1:0] op, input logic [AW-1:0] a,
                          output logic d, output logic oe);
    for (int i = 0; i < nz; i++) pulse(1'b0, d, oe);
    pulse(1'b1, d, oe);
    pulse(op[1], d, oe);
    pulse(op[0], d, oe);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i], d, oe);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int nw, input int nz);
    logic d, oe;
    logic [DW-1:0] word;
    cs_cycle();
    send_hdr(nz, 2'b10, a, d, oe);
    chk("R3 dummy zero", {30'd0, oe, d}, 32'd2);
    for (int w = 0; w < nw; w++) begin
      word = '0;
      for (int b = 0; b < DW; b++) begin
        pulse(1'b0, d, oe);
        word = {word[DW-2:0], d};
      end
      chk((w == 0) ? "R4 read word" : "R5 next word", 32'(word),
          32'(ref_mem[(int'(a) + w) % 64]));
    end
    cs_i = 1'b0;
    tick(4);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input int nz);
    logic d, oe;
    cs_cycle();
    send_hdr(nz, 2'b01, a, d, oe);
    for (int b = DW - 1; b >= 0; b--) pulse(v[b], d, oe);
    cs_i = 1'b0;
    ref_mem[a] = v;
    tick(4);
    cs_i = 1'b1;
    tick(4);
    chk("R7 busy", {30'd0, do_oe_o, do_o}, 32'd2);
    tick(WC);
    chk("R7 ready", {30'd0, do_oe_o, do_o}, 32'd3);
    pulse(1'b1, d, oe);
    chk("R8 status off after start", 32'(oe), 32'd0);
    cs_i = 1'b0;
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic d, oe, seen;
    void'($urandom(32'h1a2b3c4d));
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    tick(5);
    chk("R1 reset", 32'(do_oe_o), 32'd0);
    rst_ni = 1'b1;
    tick(3);
    chk("R1 after reset", 32'(do_oe_o), 32'd0);

    // R2: only zeros with CS high start nothing
    cs_i = 1'b1;
    tick(4);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      pulse(1'b0, d, oe);
      seen |= oe;
    end
    chk("R2 zeros ignored", 32'(seen), 32'd0);
    cs_i = 1'b0;
    tick(4);

    // R5 wrap 63 -> 0
    do_write(6'd63, 16'hA5C3, 0);
    do_write(6'd0, 16'h1234, 2);
    do_write(6'd1, 16'h8001, 1);
    do_read(6'd63, 3, 0);
    do_read(6'd62, 4, 3);

    // R9 write cut short: nothing stored, no status
    cs_cycle();
    send_hdr(0, 2'b01, 6'd0, d, oe);
    for (int b = 0; b < 8; b++) pulse(1'b1, d, oe);
    cs_i = 1'b0;
    tick(4);
    cs_i = 1'b1;
    tick(WC / 2);
    chk("R9 no status after abort", 32'(do_oe_o), 32'd0);
    cs_i = 1'b0;
    tick(4);
    do_read(6'd0, 1, 0);  // R9 stored word unchanged

    // R9 read cut mid-address, then a normal read decodes
    cs_cycle();
    pulse(1'b1, d, oe);
    pulse(1'b1, d, oe);
    pulse(1'b0, d, oe);
    pulse(1'b1, d, oe);
    do_read(6'd1, 1, 1);

    // R10 unused opcodes
    for (int k = 0; k < 2; k++) begin
      logic [1:0] op;
      op = (k == 0) ? 2'b00 : 2'b11;
      cs_cycle();
      send_hdr(0, op, 6'd63, d, oe);
      seen = oe;
      for (int b = 0; b < DW; b++) begin
        pulse(1'b0, d, oe);
        seen |= oe;
      end
      chk("R10 no drive on unused opcode", 32'(seen), 32'd0);
      cs_i = 1'b0;
      tick(4);
      cs_i = 1'b1;
      tick(8);
      chk("R10 no status on unused opcode", 32'(do_oe_o), 32'd0);
      cs_i = 1'b0;
      tick(4);
      do_read(6'd63, 1, 0);  // R10 word unchanged
    end

    // random mix, R2 leading zeros, R4/R5/R6 via read-back
    for (int it = 0; it < 30; it++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 63));
      if ($urandom_range(0, 1) == 1)
        do_write(a, DW'($urandom), int'($urandom_range(0, 3)));
      else
        do_read(a, int'($urandom_range(1, 3)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule